// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that sends and receives a queue of up to sixteen words on its own, with no host action between words. The host programs it over a simple 16-bit register bus with a single-cycle access. Three 16-entry internal memories hold the data: one for outgoing words, one for incoming words and one for per-entry commands. All three are reached indirectly, through a pointer register and a data window register. The pointer steps forward by one on every access to the window.

After it has loaded the memories and set the serial format, the host gives a first and a last queue index and sets the run bit. For each entry the controller shifts one word on MOSI and samples one word from MISO. It stores the received word at the matching receive entry, and then moves on to the next index. When the last entry finishes, it clears the run bit and sets a completion flag. The flag can drive an interrupt. Chip selects are outside this block.

Top module: `spi_queue_master`

## Requirements
- R1: The registers sit at byte offsets 0x00 (format), 0x04 (control), 0x08 (queue bounds), 0x0C (interrupt), 0x10 (pointer) and 0x14 (data window), and all read 0 after reset. The format register reads back all 16 bits. The bounds register keeps the last index in bits 11:8 and the first index in bits 3:0, and its other bits read 0.
- R2: The 6-bit pointer selects the memory. Values 0x00-0x0F address the transmit memory, 0x10-0x1F the receive memory and 0x20-0x2F the command memory. Every read or write of the data window advances the pointer by one, wrapping from 0x3F to 0x00. Addresses 0x30-0x3F read as 0 and ignore writes.
- R3: Host writes through the data window into the receive range leave the receive memory unchanged.
- R4: Writing 1 to control bit 15 starts the queue. The queue runs from the first index through the last index inclusive, and the index wraps from 15 to 0. Control bit 15 reads 1 while the queue runs, and hardware clears it when the last entry finishes.
- R5: When the queue finishes, interrupt register bit 0 (done flag) is set. `irq` equals the done flag ANDed with interrupt register bit 8. Writing 1 to bit 0 clears the flag. If a clearing write falls in the same cycle as completion, the flag ends up set.
- R6: Command entry bit 14 set selects the word length from format bits 13:10: values 8 to 15 are used as given, and values 0 to 7 mean 16. With bit 14 clear, the word is 8 bits.
- R7: Each word is sent MSB first on MOSI. The received word is right-justified and written to the receive entry with the same index as the command entry that produced it.
- R8: SCK rests at the level of format bit 9 outside a word. With format bit 8 at 0, data is captured on the first edge of each bit and changes on the second edge. With bit 8 at 1, data changes on the first edge and is captured on the second.
- R9: Each SCK half period lasts as many clock cycles as format bits 7:0 give, and a word of n bits has exactly 2n SCK edges.
- R10: With a divisor of 0, SCK stops, the queue stalls and control bit 15 stays set. Once a nonzero divisor is written, the queue resumes and completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Completion interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two events can land in the same cycle: the host clearing the done flag, and the hardware setting it as the last entry finishes. The bench provokes this by holding a write-one-to-clear on the interrupt register every cycle while a queue runs, and stops as soon as `irq` is seen high. The correct result is a set flag, because set must win. If the clear won instead, the flag would never stay up and the bounded hammer would end with it reading 0. A bench-side SPI slave model, driven by the programmed polarity and phase, checks bit order, edge counts and half-period length against its own expected values.

// File: rtl/spq_pkg.sv
package spq_pkg;
    localparam int DATA_W = 16;
    localparam int QDEPTH = 16;
    localparam int QIDX_W = $clog2(QDEPTH);
    localparam int PTR_W  = QIDX_W + 2;
    localparam int NBANK  = 3;
    localparam int BAUD_W = 8;
    localparam int BITS_W = 4;
    localparam int NB_W   = $clog2(DATA_W + 1);
    localparam int ECNT_W = $clog2(2 * DATA_W);
    localparam int CMD_USE_BITS = 14;

    localparam logic [4:0] OFS_FMT  = 5'h00;
    localparam logic [4:0] OFS_CTRL = 5'h04;
    localparam logic [4:0] OFS_BND  = 5'h08;
    localparam logic [4:0] OFS_INT  = 5'h0C;
    localparam logic [4:0] OFS_PTR  = 5'h10;
    localparam logic [4:0] OFS_WIN  = 5'h14;

    typedef enum logic [1:0] {
        BANK_TX   = 2'd0,
        BANK_RX   = 2'd1,
        BANK_CMD  = 2'd2,
        BANK_NONE = 2'd3
    } bank_e;

    typedef struct packed {
        logic              master;
        logic              spare;
        logic [BITS_W-1:0] bits;
        logic              cpol;
        logic              cpha;
        logic [BAUD_W-1:0] baud;
    } fmt_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_LOAD  = 2'd1,
        ENG_SHIFT = 2'd2
    } eng_state_e;

    function automatic logic [NB_W-1:0] word_len(input logic use_bits,
                                                 input logic [BITS_W-1:0] bits);
        if (!use_bits)
            return NB_W'(8);
        else if (bits < BITS_W'(8))
            return NB_W'(DATA_W);
        else
            return NB_W'(bits);
    endfunction
endpackage

// File: rtl/spq_ram.sv
module spq_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_b
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/spq_clkdiv.sv
module spq_clkdiv #(
    parameter int BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [BAUD_W-1:0] baud,
    output logic              tick
);
    logic [BAUD_W-1:0] cnt;

    assign tick = en && (baud != '0) && (cnt == baud - BAUD_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en || baud == '0 || tick)
            cnt <= '0;
        else
            cnt <= cnt + BAUD_W'(1);
    end
endmodule

// File: rtl/spq_engine.sv
module spq_engine
    import spq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [BITS_W-1:0] bits,
    input  logic [BAUD_W-1:0] baud,
    input  logic [QIDX_W-1:0] q_first,
    input  logic [QIDX_W-1:0] q_last,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              use_bits,
    input  logic              miso,
    output logic [QIDX_W-1:0] idx,
    output logic              rx_we,
    output logic [DATA_W-1:0] rx_data,
    output logic              done,
    output logic              sck,
    output logic              mosi
);
    eng_state_e        state;
    logic [NB_W-1:0]   nbits;
    logic [ECNT_W-1:0] edge_cnt;
    logic [DATA_W-1:0] tx_sr, rx_sr, sr_init;
    logic [NB_W-1:0]   ld_n;
    logic              phase, tick, leading, sample, drive, last_edge, last_sample;

    spq_clkdiv #(.BAUD_W(BAUD_W)) u_div (
        .clk (clk),
        .rst (rst),
        .en  (state == ENG_SHIFT),
        .baud(baud),
        .tick(tick)
    );

    always_comb begin
        ld_n        = word_len(use_bits, bits);
        sr_init     = tx_word << (NB_W'(DATA_W) - ld_n);
        leading     = ~edge_cnt[0];
        last_edge   = {1'b0, edge_cnt} == ({nbits, 1'b0} - 6'd1);
        last_sample = {1'b0, edge_cnt} == ({nbits, 1'b0} - 6'd2 + {5'd0, cpha});
        sample      = cpha ? ~leading : leading;
        drive       = cpha ? leading : (~leading && !last_edge);
    end

    assign sck     = cpol ^ phase;
    assign rx_data = {rx_sr[DATA_W-2:0], miso};
    assign rx_we   = (state == ENG_SHIFT) && tick && sample && last_sample;
    assign done    = (state == ENG_SHIFT) && tick && last_edge && (idx == q_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            idx      <= '0;
            nbits    <= NB_W'(8);
            edge_cnt <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            phase    <= 1'b0;
            mosi     <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (go) begin
                        idx   <= q_first;
                        state <= ENG_LOAD;
                    end
                end
                ENG_LOAD: begin
                    nbits    <= ld_n;
                    edge_cnt <= '0;
                    phase    <= 1'b0;
                    rx_sr    <= '0;
                    if (!cpha) begin
                        mosi  <= sr_init[DATA_W-1];
                        tx_sr <= sr_init << 1;
                    end else begin
                        tx_sr <= sr_init;
                    end
                    state <= ENG_SHIFT;
                end
                ENG_SHIFT: begin
                    if (tick) begin
                        phase    <= ~phase;
                        edge_cnt <= edge_cnt + ECNT_W'(1);
                        if (sample) rx_sr <= rx_data;
                        if (drive) begin
                            mosi  <= tx_sr[DATA_W-1];
                            tx_sr <= tx_sr << 1;
                        end
                        if (last_edge) begin
                            edge_cnt <= '0;
                            if (idx == q_last) begin
                                state <= ENG_IDLE;
                            end else begin
                                idx   <= idx + QIDX_W'(1);
                                state <= ENG_LOAD;
                            end
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R8: clock rests at the polarity level whenever no word is shifting
    a_r8_idle_level: assert property (@(posedge clk) disable iff (rst)
        (state != ENG_SHIFT) |-> (sck == cpol));

    // R9: never more than 2n edges within a word
    a_r9_edge_bound: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_SHIFT) |-> ({1'b0, edge_cnt} < {nbits, 1'b0}));

    // R10: a zero divisor freezes the serial clock
    a_r10_stall: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_SHIFT && baud == '0) |=> $stable(phase));
endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master
    import spq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq,
    output logic        sck,
    output logic        mosi,
    input  logic        miso
);
    fmt_t              fmt_q;
    logic              run_q, flag_q, ien_q;
    logic [QIDX_W-1:0] first_q, last_q;
    logic [PTR_W-1:0]  ptr_q;

    logic              win_acc;
    bank_e             host_bank;
    logic [NBANK-1:0]  host_we;
    logic [DATA_W-1:0] rd_host [NBANK];
    logic [DATA_W-1:0] rd_eng  [NBANK];
    logic [DATA_W-1:0] win_rd;

    logic [QIDX_W-1:0] eng_idx;
    logic              eng_rx_we, eng_done;
    logic [DATA_W-1:0] eng_rx_data;

    assign win_acc   = bus_sel && (bus_addr == OFS_WIN);
    assign host_bank = bank_e'(ptr_q[PTR_W-1 -: 2]);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        if (g == int'(BANK_RX)) begin : g_rx
            assign host_we[g] = 1'b0;
            spq_ram #(.DEPTH(QDEPTH), .WIDTH(DATA_W)) u_ram (
                .clk(clk), .rst(rst),
                .we(eng_rx_we), .waddr(eng_idx), .wdata(eng_rx_data),
                .raddr_a(ptr_q[QIDX_W-1:0]), .rdata_a(rd_host[g]),
                .raddr_b(eng_idx), .rdata_b(rd_eng[g])
            );
        end else begin : g_host
            assign host_we[g] = win_acc && bus_we && (host_bank == bank_e'(g));
            spq_ram #(.DEPTH(QDEPTH), .WIDTH(DATA_W)) u_ram (
                .clk(clk), .rst(rst),
                .we(host_we[g]), .waddr(ptr_q[QIDX_W-1:0]), .wdata(bus_wdata),
                .raddr_a(ptr_q[QIDX_W-1:0]), .rdata_a(rd_host[g]),
                .raddr_b(eng_idx), .rdata_b(rd_eng[g])
            );
        end
    end

    logic unused_bits;
    assign unused_bits = ^{rd_eng[BANK_RX], rd_eng[BANK_CMD][DATA_W-1:CMD_USE_BITS+1],
                           rd_eng[BANK_CMD][CMD_USE_BITS-1:0]};

    spq_engine u_eng (
        .clk(clk), .rst(rst), .go(run_q),
        .cpol(fmt_q.cpol), .cpha(fmt_q.cpha), .bits(fmt_q.bits), .baud(fmt_q.baud),
        .q_first(first_q), .q_last(last_q),
        .tx_word(rd_eng[BANK_TX]), .use_bits(rd_eng[BANK_CMD][CMD_USE_BITS]),
        .miso(miso), .idx(eng_idx), .rx_we(eng_rx_we), .rx_data(eng_rx_data),
        .done(eng_done), .sck(sck), .mosi(mosi)
    );

    always_comb begin
        case (host_bank)
            BANK_TX:  win_rd = rd_host[BANK_TX];
            BANK_RX:  win_rd = rd_host[BANK_RX];
            BANK_CMD: win_rd = rd_host[BANK_CMD];
            default:  win_rd = '0;
        endcase
    end

    always_comb begin
        case (bus_addr)
            OFS_FMT:  bus_rdata = fmt_q;
            OFS_CTRL: bus_rdata = {run_q, 15'd0};
            OFS_BND:  bus_rdata = {4'd0, last_q, 4'd0, first_q};
            OFS_INT:  bus_rdata = {7'd0, ien_q, 7'd0, flag_q};
            OFS_PTR:  bus_rdata = {{(DATA_W-PTR_W){1'b0}}, ptr_q};
            OFS_WIN:  bus_rdata = win_rd;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = flag_q && ien_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q   <= '0;
            run_q   <= 1'b0;
            flag_q  <= 1'b0;
            ien_q   <= 1'b0;
            first_q <= '0;
            last_q  <= '0;
            ptr_q   <= '0;
        end else begin
            if (bus_sel && bus_we && bus_addr == OFS_FMT) fmt_q <= fmt_t'(bus_wdata);
            if (bus_sel && bus_we && bus_addr == OFS_BND) begin
                last_q  <= bus_wdata[11:8];
                first_q <= bus_wdata[3:0];
            end
            if (bus_sel && bus_we && bus_addr == OFS_PTR) ptr_q <= bus_wdata[PTR_W-1:0];
            else if (win_acc) ptr_q <= ptr_q + PTR_W'(1);
            if (eng_done) run_q <= 1'b0;
            else if (bus_sel && bus_we && bus_addr == OFS_CTRL) run_q <= bus_wdata[15];
            if (bus_sel && bus_we && bus_addr == OFS_INT) ien_q <= bus_wdata[8];
            if (eng_done) flag_q <= 1'b1;
            else if (bus_sel && bus_we && bus_addr == OFS_INT && bus_wdata[0]) flag_q <= 1'b0;
        end
    end

    // R2: each window access steps the pointer by one
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
        win_acc |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));

    // R2, R3: at most one memory takes a host write, never the receive one
    a_r3_host_we: assert property (@(posedge clk) disable iff (rst)
        $onehot0(host_we) && !host_we[BANK_RX]);

    // R4: completion drops the run bit
    a_r4_run_clear: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> !run_q);

    // R5: completion always leaves the flag set
    a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> flag_q);
endmodule

// File: tb/tb_spi_queue_master.sv
module tb_spi_queue_master;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        irq, sck, mosi, miso;

    always #2 clk = ~clk;

    spi_queue_master dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
    );

    localparam logic [4:0] A_FMT = 5'h00, A_CTRL = 5'h04, A_BND = 5'h08,
                           A_INT = 5'h0C, A_PTR = 5'h10, A_WIN = 5'h14;

    int n_chk = 0, n_bad = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    function automatic int wl(input bit ub, input logic [3:0] bits);
        if (!ub) return 8;
        if (bits < 4'd8) return 16;
        return int'(bits);
    endfunction

    function automatic logic [15:0] msk(input int nb);
        return (nb >= 16) ? 16'hFFFF : 16'((32'd1 << nb) - 1);
    endfunction

    // bench-side SPI slave model
    logic [15:0] sl_tx [16];
    logic [15:0] sl_cap [16];
    int          sl_nb [16];
    int          sl_pos, sl_bit, sl_wedge, edges, hp_err, cyc_since, baud_exp;
    bit          sl_arm = 0, tb_cpol, tb_cpha;
    logic        sck_prev = 1'b0;

    always_comb begin
        miso = 1'b0;
        if (sl_pos < 16 && sl_bit < sl_nb[sl_pos])
            miso = sl_tx[sl_pos][sl_nb[sl_pos] - 1 - sl_bit];
    end

    always @(negedge clk) begin
        cyc_since++;
        if (sl_arm && sck !== sck_prev && sl_pos < 16) begin
            bit lead;
            lead = (sck != tb_cpol);
            if (sl_wedge > 0 && cyc_since != baud_exp) hp_err++;
            cyc_since = 0;
            edges++;
            sl_wedge++;
            if (tb_cpha ? !lead : lead) sl_cap[sl_pos] = {sl_cap[sl_pos][14:0], mosi};
            if (!lead) begin
                sl_bit++;
                if (sl_bit == sl_nb[sl_pos]) begin
                    sl_bit = 0; sl_wedge = 0; sl_pos++;
                end
            end
        end
        sck_prev = sck;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    logic [15:0] tx_mem [16];

    // how: 0 normal, 1 start with zero divisor, 2 hammer done-flag clears
    task automatic run_q(input bit cpol, input bit cpha, input logic [3:0] bits,
                         input logic [7:0] baud, input logic [3:0] qs,
                         input logic [3:0] qe, input logic [15:0] ubmask, input int how);
        int          exp_idx [16];
        int          nq, tot, n, e;
        logic [15:0] d;
        bit          got;
        sl_arm = 0;
        wr(A_FMT, {1'b1, 1'b0, bits, cpol, cpha, (how == 1) ? 8'd0 : baud});
        wr(A_PTR, 16'h0000);
        for (int i = 0; i < 16; i++) begin
            tx_mem[i] = 16'($urandom);
            wr(A_WIN, tx_mem[i]);
        end
        wr(A_PTR, 16'h0020);
        for (int i = 0; i < 16; i++)
            wr(A_WIN, {1'($urandom), ubmask[i], 1'($urandom), 13'd0});
        wr(A_BND, {4'd0, qe, 4'd0, qs});
        wr(A_INT, 16'h0101);
        nq = 0; tot = 0; e = int'(qs);
        forever begin
            exp_idx[nq] = e;
            sl_nb[nq]   = wl(ubmask[e], bits);
            sl_tx[nq]   = 16'($urandom) & msk(sl_nb[nq]);
            sl_cap[nq]  = '0;
            tot += sl_nb[nq];
            nq++;
            if (e == int'(qe)) break;
            e = (e + 1) % 16;
        end
        for (int i = nq; i < 16; i++) begin sl_nb[i] = 8; sl_tx[i] = '0; sl_cap[i] = '0; end
        @(negedge clk);
        sl_pos = 0; sl_bit = 0; sl_wedge = 0; edges = 0; hp_err = 0; cyc_since = 0;
        baud_exp = int'(baud); tb_cpol = cpol; tb_cpha = cpha; sck_prev = sck;
        sl_arm = 1;
        wr(A_CTRL, 16'h8000);
        if (how == 1) begin
            repeat (100) @(negedge clk);
            chk(sck == cpol, "R10 clock frozen at rest level", 32'(sck), 32'(cpol));
            chk(edges == 0, "R10 no edges with zero divisor", edges, 0);
            rd(A_CTRL, d);
            chk(d == 16'h8000, "R10 run bit held while stalled", d, 16'h8000);
            wr(A_FMT, {1'b1, 1'b0, bits, cpol, cpha, baud});
        end
        got = 0; n = 0;
        if (how == 2) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_INT; bus_wdata = 16'h0101;
            while (!irq && n < 40000) begin @(negedge clk); n++; end
            bus_sel = 1'b0; bus_we = 1'b0;
            got = irq;
            rd(A_INT, d);
            chk(d[0] == 1'b1, "R5 set wins over same-cycle clear", d, 16'h0101);
        end else begin
            while (!irq && n < 40000) begin @(negedge clk); n++; end
            got = irq;
        end
        chk(got, "R5 irq raised on completion", 32'(got), 1);
        rd(A_CTRL, d);
        chk(d == 16'h0000, "R4 run bit cleared by hardware", d, 0);
        chk(sck == cpol, "R8 clock rests at polarity after queue", 32'(sck), 32'(cpol));
        chk(sl_pos == nq, "R4 number of entries run", sl_pos, nq);
        chk(edges == 2 * tot, "R9 edge count equals 2n per word", edges, 2 * tot);
        chk(hp_err == 0, "R9 half period equals divisor", hp_err, 0);
        for (int p = 0; p < nq; p++) begin
            logic [15:0] want;
            want = tx_mem[exp_idx[p]] & msk(sl_nb[p]);
            chk(sl_cap[p] == want, "R7 R8 R6 word seen by slave", sl_cap[p], want);
            wr(A_PTR, 16'(16 + exp_idx[p]));
            rd(A_WIN, d);
            chk(d == sl_tx[p], "R7 received word stored right-justified", d, sl_tx[p]);
        end
        sl_arm = 0;
    endtask

    initial begin
        logic [15:0] d;
        void'($urandom(32'h5eed1234));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(A_FMT, d);  chk(d == 0, "R1 format reset", d, 0);
        rd(A_CTRL, d); chk(d == 0, "R1 control reset", d, 0);
        rd(A_BND, d);  chk(d == 0, "R1 bounds reset", d, 0);
        rd(A_INT, d);  chk(d == 0, "R1 interrupt reset", d, 0);
        rd(A_PTR, d);  chk(d == 0, "R1 pointer reset", d, 0);
        chk(sck == 0 && irq == 0, "R1 outputs at reset", {sck, irq}, 0);

        // R1 readback
        wr(A_FMT, 16'hC5A3); rd(A_FMT, d); chk(d == 16'hC5A3, "R1 format readback", d, 16'hC5A3);
        wr(A_BND, 16'hFFFF); rd(A_BND, d); chk(d == 16'h0F0F, "R1 bounds readback", d, 16'h0F0F);
        wr(A_FMT, 16'h0000);

        // R2 pointer stepping and banks
        wr(A_PTR, 16'h0005);
        wr(A_WIN, 16'h1111); wr(A_WIN, 16'h2222); wr(A_WIN, 16'h3333);
        rd(A_PTR, d); chk(d == 16'h0008, "R2 pointer after three writes", d, 8);
        wr(A_PTR, 16'h0006); rd(A_WIN, d); chk(d == 16'h2222, "R2 transmit readback", d, 16'h2222);
        rd(A_PTR, d); chk(d == 16'h0007, "R2 pointer after read", d, 7);
        wr(A_PTR, 16'h0025); wr(A_WIN, 16'hABCD);
        wr(A_PTR, 16'h0025); rd(A_WIN, d); chk(d == 16'hABCD, "R2 command readback", d, 16'hABCD);
        wr(A_PTR, 16'h0030); wr(A_WIN, 16'h5555);
        rd(A_PTR, d); chk(d == 16'h0031, "R2 unmapped write steps pointer", d, 16'h31);
        wr(A_PTR, 16'h0030); rd(A_WIN, d); chk(d == 16'h0000, "R2 unmapped reads zero", d, 0);
        wr(A_PTR, 16'h003F); rd(A_WIN, d);
        rd(A_PTR, d); chk(d == 16'h0000, "R2 pointer wraps", d, 0);

        // directed queues
        run_q(1'b0, 1'b0, 4'd0, 8'd1, 4'd0, 4'd15, 16'hFFFF, 0); // R6 16-bit full queue
        // R3 host write into receive range ignored
        wr(A_PTR, 16'h0013); rd(A_WIN, d);
        begin
            logic [15:0] keep;
            keep = d;
            wr(A_PTR, 16'h0013); wr(A_WIN, ~keep);
            wr(A_PTR, 16'h0013); rd(A_WIN, d);
            chk(d == keep, "R3 receive memory unchanged by host write", d, keep);
        end
        run_q(1'b1, 1'b1, 4'd8,  8'd3, 4'd14, 4'd2, 16'hFFFF, 0); // wrap-around
        run_q(1'b1, 1'b0, 4'd12, 8'd2, 4'd5,  4'd5, 16'h0020, 0); // single entry
        run_q(1'b0, 1'b1, 4'd13, 8'd2, 4'd3,  4'd6, 16'h0000, 0); // R6 8-bit when bit 14 clear
        run_q(1'b1, 1'b1, 4'd10, 8'd2, 4'd0,  4'd0, 16'h0001, 1); // R10 stall
        run_q(1'b0, 1'b0, 4'd9,  8'd1, 4'd7,  4'd8, 16'hFFFF, 2); // R5 coincidence

        // random mix
        for (int t = 0; t < 10; t++) begin
            run_q(1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom_range(1, 4)),
                  4'($urandom), 4'($urandom), 16'($urandom), 0);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule